// File: doc/BRIEF.md
# Four-Slot Frame Rate Converter Controller

This block arbitrates four frame buffers kept in a ring, so that a producer that completes frames at a slow rate (48 per second) and a consumer that displays frames at a faster rate (60 per second) never touch the same buffer. It does not move pixel data. It tracks which slot the writer is filling and which slot the reader is showing. A per-slot flag marks each slot as fresh (a complete frame not yet consumed) or free (open to be rewritten).

The writer pulses a done strobe when a whole frame has landed in its slot. The controller then marks that slot fresh and hands the writer the next slot in ring order. It skips one slot further when that slot is the one on display. The reader pulses a start strobe before each output frame. The controller then points it at the first fresh slot found going forward around the ring. If there is none, it keeps the slot already on display, so the faster reader repeats frames. The reader's done strobe releases the displayed frame by clearing that slot's fresh flag. Until the first frame has been completed, the reader is told to show a blank frame.

Top module: `frame_ring_ctrl`

## Requirements
- R1: After reset, wr_slot_o is 0 (slot A), rd_slot_o is 3 (slot D, so that the first scan starts at A) and rd_valid_o is 0. Slots are numbered A=0, B=1, C=2, D=3, and all fresh flags are clear.
- R2: Each wr_done_i pulse moves wr_slot_o forward one step in ring order (0,1,2,3,0), visible the next cycle. Without a pulse wr_slot_o holds.
- R3: While no frame has yet been offered to the reader, a rd_start_i pulse leaves rd_valid_o at 0 (blank frame).
- R4: On a rd_start_i pulse the reader takes the first slot holding a fresh frame, searching rd_slot_o+1, +2, +3 (mod 4), and rd_valid_o becomes 1. Both are visible the next cycle.
- R5: If no slot ahead holds a fresh frame when rd_start_i pulses and a frame is on display, rd_slot_o is unchanged and rd_valid_o stays 1 (the frame repeats).
- R6: When the next write slot is the slot on display (rd_valid_o=1), the writer skips to the slot after it. The writer is never given the displayed slot.
- R7: When wr_done_i and rd_start_i pulse in the same cycle, the reader decides on the flags from before that cycle, so it does not take the slot completed in that cycle. The writer avoids the slot the reader picks in that cycle.
- R8: Moving the writer into a slot clears that slot's fresh flag, so a frame being overwritten is never offered to the reader.
- R9: A rd_done_i pulse while rd_valid_o is 0 has no effect on any output.
- R10: Under continuous 4-to-5 write-to-read pacing, the writer slot never equals the displayed slot while rd_valid_o is 1. rd_slot_o changes only on a rd_start_i pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_done_i | input | 1 | Single-cycle pulse: writer finished a whole frame |
| rd_start_i | input | 1 | Single-cycle pulse: reader begins the next output frame |
| rd_done_i | input | 1 | Single-cycle pulse: reader finished the displayed frame |
| wr_slot_o | output | 2 | Slot the writer must fill |
| rd_slot_o | output | 2 | Slot the reader must display |
| rd_valid_o | output | 1 | 1 when rd_slot_o holds a frame, 0 means output blank |

## Verification
Every output is registered, so the response to a strobe appears in the cycle after the rising edge that captured it: the new write slot after wr_done_i, and the new read slot and valid bit after rd_start_i. The bench changes strobes on the falling edge and holds them for exactly one cycle. It reads the outputs on the next falling edge, which is half a period after the capturing edge, so each check lands in the first cycle where the new value is due. Same-cycle strobe pairs are driven in one such cycle, so the check sees the combined decision.

// File: rtl/frc_pkg.sv
`timescale 1ns/1ps
package frc_pkg;
  // modular step around the slot ring
  function automatic int unsigned ring_add(input int unsigned s, input int unsigned d,
                                           input int unsigned n);
    return (s + d) % n;
  endfunction
endpackage

// File: rtl/frc_slot_flags.sv
`timescale 1ns/1ps
module frc_slot_flags #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_en_i,
  input  logic [IDX_W-1:0]     set_idx_i,
  input  logic                 rel_en_i,
  input  logic [IDX_W-1:0]     rel_idx_i,
  input  logic                 ovw_en_i,
  input  logic [IDX_W-1:0]     ovw_idx_i,
  output logic [NUM_SLOTS-1:0] fresh_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_set, hit_clr;
    assign hit_set = set_en_i && (set_idx_i == IDX_W'(g));
    assign hit_clr = (rel_en_i && (rel_idx_i == IDX_W'(g))) ||
                     (ovw_en_i && (ovw_idx_i == IDX_W'(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      fresh_o[g] <= 1'b0;
      else if (hit_set) fresh_o[g] <= 1'b1;
      else if (hit_clr) fresh_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/frc_write_ptr.sv
`timescale 1ns/1ps
module frc_write_ptr
  import frc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_done_i,
  input  logic             excl_en_i,
  input  logic [IDX_W-1:0] excl_idx_i,
  output logic [IDX_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0] wr_next_o,
  output logic             wr_move_o
);
  logic [IDX_W-1:0] step1, step2;

  assign step1 = IDX_W'(ring_add(int'(wr_slot_o), 1, NUM_SLOTS));
  assign step2 = IDX_W'(ring_add(int'(wr_slot_o), 2, NUM_SLOTS));
  // skip the slot the reader holds
  assign wr_next_o = (excl_en_i && (step1 == excl_idx_i)) ? step2 : step1;
  assign wr_move_o = wr_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wr_slot_o <= '0;
    else if (wr_done_i) wr_slot_o <= wr_next_o;
  end
endmodule

// File: rtl/frc_read_sel.sv
`timescale 1ns/1ps
module frc_read_sel
  import frc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_start_i,
  input  logic [NUM_SLOTS-1:0] fresh_i,
  output logic [IDX_W-1:0]     rd_slot_o,
  output logic                 rd_valid_o,
  output logic [IDX_W-1:0]     pick_o,
  output logic                 take_o
);
  logic             found;
  logic [IDX_W-1:0] cand;

  // nearest fresh slot ahead wins: scan far to near
  always_comb begin
    found  = 1'b0;
    pick_o = rd_slot_o;
    cand   = '0;
    for (int k = NUM_SLOTS - 1; k >= 1; k--) begin
      cand = IDX_W'(ring_add(int'(rd_slot_o), k, NUM_SLOTS));
      if (fresh_i[cand]) begin
        found  = 1'b1;
        pick_o = cand;
      end
    end
  end

  assign take_o = rd_start_i && found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_slot_o  <= IDX_W'(NUM_SLOTS - 1);
      rd_valid_o <= 1'b0;
    end else if (take_o) begin
      rd_slot_o  <= pick_o;
      rd_valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_ring_ctrl.sv
`timescale 1ns/1ps
module frame_ring_ctrl #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_done_i,
  input  logic             rd_start_i,
  input  logic             rd_done_i,
  output logic [IDX_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0] rd_slot_o,
  output logic             rd_valid_o
);
  logic [NUM_SLOTS-1:0] fresh;
  logic [IDX_W-1:0]     wr_next, rd_pick, excl_idx;
  logic                 wr_move, rd_take, excl_en;

  // reader reservation: new pick this cycle, else the slot on display
  assign excl_en  = rd_take || rd_valid_o;
  assign excl_idx = rd_take ? rd_pick : rd_slot_o;

  frc_slot_flags #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (wr_done_i),
    .set_idx_i (wr_slot_o),
    .rel_en_i  (rd_done_i && rd_valid_o),
    .rel_idx_i (rd_slot_o),
    .ovw_en_i  (wr_move),
    .ovw_idx_i (wr_next),
    .fresh_o   (fresh)
  );

  frc_write_ptr #(.NUM_SLOTS(NUM_SLOTS)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_done_i  (wr_done_i),
    .excl_en_i  (excl_en),
    .excl_idx_i (excl_idx),
    .wr_slot_o  (wr_slot_o),
    .wr_next_o  (wr_next),
    .wr_move_o  (wr_move)
  );

  frc_read_sel #(.NUM_SLOTS(NUM_SLOTS)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (rd_start_i),
    .fresh_i    (fresh),
    .rd_slot_o  (rd_slot_o),
    .rd_valid_o (rd_valid_o),
    .pick_o     (rd_pick),
    .take_o     (rd_take)
  );
endmodule

// File: rtl/frame_ring_ctrl_chk.sv
`timescale 1ns/1ps
module frame_ring_ctrl_chk #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_done_i,
  input logic             rd_start_i,
  input logic [IDX_W-1:0] wr_slot_o,
  input logic [IDX_W-1:0] rd_slot_o,
  input logic             rd_valid_o
);
  // R2
  a_r2_wr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_i |=> wr_slot_o != $past(wr_slot_o));
  // R2
  a_r2_wr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_done_i |=> $stable(wr_slot_o));
  // R6, R10
  a_r10_no_share: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> wr_slot_o != rd_slot_o);
  // R10
  a_r10_rd_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_start_i |=> $stable(rd_slot_o));
  // R5
  a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> rd_valid_o);
  // R3
  a_r3_blank_until_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_o && !rd_start_i) |=> !rd_valid_o);
endmodule

bind frame_ring_ctrl frame_ring_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_done_i  (wr_done_i),
  .rd_start_i (rd_start_i),
  .wr_slot_o  (wr_slot_o),
  .rd_slot_o  (rd_slot_o),
  .rd_valid_o (rd_valid_o)
);

// File: tb/frame_ring_ctrl_test.sv
`timescale 1ns/1ps
module frame_ring_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_done_i = 1'b0, rd_start_i = 1'b0, rd_done_i = 1'b0;
  logic [1:0] wr_slot_o, rd_slot_o;
  logic       rd_valid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  frame_ring_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_done_i(wr_done_i), .rd_start_i(rd_start_i),
    .rd_done_i(rd_done_i), .wr_slot_o(wr_slot_o), .rd_slot_o(rd_slot_o),
    .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle strobe, returns at the next falling edge
  task automatic pulse(input bit wd, input bit rs, input bit rd);
    @(negedge clk_i);
    wr_done_i = wd; rd_start_i = rs; rd_done_i = rd;
    @(negedge clk_i);
    wr_done_i = 1'b0; rd_start_i = 1'b0; rd_done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wr_slot", wr_slot_o, 0);
    chk("R1 rd_slot", rd_slot_o, 3);
    chk("R1 rd_valid", rd_valid_o, 0);
  endtask

  task automatic t_blank();
    pulse(0, 1, 0);
    chk("R3 blank valid", rd_valid_o, 0);
    chk("R3 blank slot", rd_slot_o, 3);
    pulse(0, 0, 1);
    chk("R9 stray done valid", rd_valid_o, 0);
    chk("R9 stray done wr", wr_slot_o, 0);
  endtask

  task automatic t_write_ring();
    for (int i = 1; i <= 4; i++) begin
      pulse(1, 0, 0);
      chk("R2 wr step", wr_slot_o, i % 4);
    end
    pulse(0, 0, 0);
    chk("R2 wr hold", wr_slot_o, 0);
  endtask

  task automatic t_first_read();
    // A was overwritten by writer wrap, B is first fresh
    pulse(0, 1, 0);
    chk("R8 skip overwritten", rd_slot_o, 1);
    chk("R4 valid", rd_valid_o, 1);
  endtask

  task automatic t_skip();
    pulse(1, 0, 0);
    chk("R6 writer skip", wr_slot_o, 2);
    pulse(0, 0, 1);
    pulse(0, 1, 0);
    chk("R4 next fresh", rd_slot_o, 3);
    pulse(0, 1, 1);
    chk("R4 wrap read", rd_slot_o, 0);
    chk("R10 wr unchanged by reads", wr_slot_o, 2);
  endtask

  task automatic t_repeat();
    pulse(0, 0, 1);
    pulse(0, 1, 0);
    chk("R5 repeat slot", rd_slot_o, 0);
    chk("R5 repeat valid", rd_valid_o, 1);
  endtask

  task automatic t_same_cycle();
    pulse(1, 1, 0);
    chk("R7 reader ignores same-cycle frame", rd_slot_o, 0);
    chk("R7 writer step", wr_slot_o, 3);
    pulse(0, 1, 1);
    chk("R7 frame taken later", rd_slot_o, 2);
  endtask

  task automatic t_rate();
    int prev_rd;
    for (int i = 0; i < 60; i++) begin
      bit rs;
      prev_rd = rd_slot_o;
      rs = (i % 4 == 0);
      pulse(i % 5 == 2, rs, rs);
      if (!rs) chk("R10 rd hold", rd_slot_o, prev_rd);
      chk("R10 no share", int'(wr_slot_o != rd_slot_o), 1);
      chk("R10 valid kept", rd_valid_o, 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_blank();
    t_write_ring();
    t_first_read();
    t_skip();
    t_repeat();
    t_same_cycle();
    t_rate();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule